// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit gathers fourteen serial-port event sources into one sticky status register. Each bit is masked by a matching enable register, and the result drives a single active-high, level-sensitive interrupt request. The event sources are the FIFO thresholds, receiver errors, transmitter underrun, break completion, a bus error response and changes on the clear-to-send line. A status bit latches when its event arrives, whatever the enable setting says. It stays set until software writes a one to that bit position in the status register.

Software reaches the unit through a small register port with a two-bit select. It can write the full enable word. It can also switch the receive-side or the transmit-side enables on or off as a group with one write, and leave the other enables alone. The clear-to-send input is synchronised inside the unit. The unit raises the toggle status bit itself on every change of that line, so the matching event input is not used.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the status register, the enable register and irq_o are all zero.
- R2: A high evt_i bit in a cycle sets the status bit of the same position at the next clock edge, whether or not that bit is enabled. The bit then holds until it is cleared. Bit positions: 0 transmit holding empty, 1 receive holding full, 2 transmit FIFO near empty, 3 transmit FIFO empty, 4 receive FIFO near full, 5 receive FIFO full, 6 transmit underrun, 7 receive overrun, 8 parity error, 9 framing error, 10 CTS changed, 11 receive timeout, 12 break finished, 13 bus error response.
- R3: A write with reg_sel = 1 clears exactly the status bits whose reg_wdata bit is 1 and leaves all others unchanged.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: irq_o is a register. After each clock edge it equals the OR over all positions of (status AND enable) as they stood before that edge.
- R6: A write with reg_sel = 0 loads the enable register from reg_wdata. Reading with reg_sel = 0 returns the enable register, and reading with reg_sel = 1 returns the status register.
- R7: A write with reg_sel = 2 changes enables by group. If reg_wdata[2] is 1, bits 4, 5, 7, 8, 9 and 11 take the value of reg_wdata[0]. If reg_wdata[3] is 1, bits 2, 3 and 6 take the value of reg_wdata[1]. All other enable bits keep their value.
- R8: Every change of cts_i sets status bit 10 on the third clock edge after the change (two synchroniser stages by default). evt_i[10] has no effect.
- R9: reg_sel = 2 and reg_sel = 3 read as zero. A write with reg_sel = 3 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 enable, 1 status, 2 group enable, 3 unused |
| reg_wdata | input | 14 | Write data |
| reg_rdata | output | 14 | Read data for the selected register (combinational) |
| evt_i | input | 14 | Event pulses or levels, one per status bit |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| irq_o | output | 1 | Interrupt request, level, active high |

## Verification
The bench aims at a clear and an event that land on the same bit in the same cycle. A design where the clear wins would lose that event, and the status read-back would show the bit as zero. It applies group enable writes and checks that bits outside the group keep their enables. A design that rewrote the whole word would then assert or drop irq_o for transmit sources it was never told about. It also times the clear-to-send toggle detection to the exact edge and checks that the raw event input for that bit is ignored. A wrong synchroniser depth or a leak from evt_i[10] would show up as a status bit set one cycle early or set with no line change.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   localparam int UIRQ_NSRC = 14;

   localparam int B_TXH_EMPTY   = 0;
   localparam int B_RXH_FULL    = 1;
   localparam int B_TXF_LOW     = 2;
   localparam int B_TXF_EMPTY   = 3;
   localparam int B_RXF_HIGH    = 4;
   localparam int B_RXF_FULL    = 5;
   localparam int B_TX_UNDER    = 6;
   localparam int B_RX_OVER     = 7;
   localparam int B_PAR_ERR     = 8;
   localparam int B_FRM_ERR     = 9;
   localparam int B_CTS_CHG     = 10;
   localparam int B_RX_IDLE     = 11;
   localparam int B_BRK_END     = 12;
   localparam int B_BUS_ERR     = 13;

   localparam logic [UIRQ_NSRC-1:0] RX_GRP_MASK =
      (UIRQ_NSRC'(1) << B_RXF_HIGH) | (UIRQ_NSRC'(1) << B_RXF_FULL) |
      (UIRQ_NSRC'(1) << B_RX_OVER)  | (UIRQ_NSRC'(1) << B_PAR_ERR)  |
      (UIRQ_NSRC'(1) << B_FRM_ERR)  | (UIRQ_NSRC'(1) << B_RX_IDLE);

   localparam logic [UIRQ_NSRC-1:0] TX_GRP_MASK =
      (UIRQ_NSRC'(1) << B_TXF_LOW) | (UIRQ_NSRC'(1) << B_TXF_EMPTY) |
      (UIRQ_NSRC'(1) << B_TX_UNDER);

   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_GROUP  = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   // bit positions inside a group-enable write word
   localparam int GW_RX_VAL   = 0;
   localparam int GW_TX_VAL   = 1;
   localparam int GW_RX_APPLY = 2;
   localparam int GW_TX_APPLY = 3;

endpackage

// File: rtl/uirq_cts_toggle.sv
module uirq_cts_toggle #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic line_i,
   output logic toggle_o
);

   if (STAGES > 4) begin : g_bad_stages
      $error("uirq_cts_toggle: STAGES must be 0 to 4");
   end

   logic line_s;
   logic prev_q;

   if (STAGES == 0) begin : g_direct
      assign line_s = line_i;
   end else if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
         if (rst) s_q <= IDLE;
         else     s_q <= line_i;
      end
      assign line_s = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
         if (rst) s_q <= {STAGES{IDLE}};
         else     s_q <= {s_q[STAGES-2:0], line_i};
      end
      assign line_s = s_q[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= IDLE;
      else     prev_q <= line_s;
   end

   assign toggle_o = (line_s != prev_q);

   // R8
   toggle_single_chk: assert property (@(posedge clk) disable iff (rst)
      toggle_o |=> !toggle_o || (STAGES == 0));

endmodule

// File: rtl/uirq_status_bank.sv
module uirq_status_bank #(
   parameter int N = 14
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);

   if (N < 1) begin : g_bad_n
      $error("uirq_status_bank: N must be positive");
   end

   logic [N-1:0] stat_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)           stat_q[i] <= 1'b0;
         else if (set_i[i]) stat_q[i] <= 1'b1;
         else if (clr_i[i]) stat_q[i] <= 1'b0;
      end

      // R2
      sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
         stat_q[i] && !clr_i[i] |=> stat_q[i]);

      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
         set_i[i] |=> stat_q[i]);

      // R3
      clear_bit_chk: assert property (@(posedge clk) disable iff (rst)
         clr_i[i] && !set_i[i] |=> !stat_q[i]);
   end

   assign stat_o = stat_q;

endmodule

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
   parameter int           N       = 14,
   parameter logic [N-1:0] RX_MASK = '0,
   parameter logic [N-1:0] TX_MASK = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         full_we,
   input  logic [N-1:0] full_d,
   input  logic         grp_we,
   input  logic         rx_apply,
   input  logic         rx_val,
   input  logic         tx_apply,
   input  logic         tx_val,
   output logic [N-1:0] en_o
);

   localparam logic [N-1:0] KEEP_MASK = ~(RX_MASK | TX_MASK);

   if ((RX_MASK & TX_MASK) != '0) begin : g_bad_overlap
      $error("uirq_enable_reg: group masks overlap");
   end

   logic [N-1:0] en_q;
   logic [N-1:0] grp_next;

   always_comb begin
      grp_next = en_q;
      if (rx_apply) grp_next = (grp_next & ~RX_MASK) | (rx_val ? RX_MASK : '0);
      if (tx_apply) grp_next = (grp_next & ~TX_MASK) | (tx_val ? TX_MASK : '0);
   end

   always_ff @(posedge clk) begin
      if (rst)          en_q <= '0;
      else if (full_we) en_q <= full_d;
      else if (grp_we)  en_q <= grp_next;
   end

   assign en_o = en_q;

   // R7
   grp_keep_chk: assert property (@(posedge clk) disable iff (rst)
      grp_we && !full_we |=> (en_q & KEEP_MASK) == ($past(en_q) & KEEP_MASK));

   // R7
   grp_rx_chk: assert property (@(posedge clk) disable iff (rst)
      grp_we && !full_we && rx_apply |=> (en_q & RX_MASK) == ($past(rx_val) ? RX_MASK : '0));

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
   import uirq_pkg::*;
#(
   parameter int   NUM_SRC    = 14,
   parameter int   CTS_STAGES = 2,
   parameter logic CTS_IDLE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               reg_wr,
   input  logic [1:0]         reg_sel,
   input  logic [NUM_SRC-1:0] reg_wdata,
   output logic [NUM_SRC-1:0] reg_rdata,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               cts_i,
   output logic               irq_o
);

   if (NUM_SRC != UIRQ_NSRC) begin : g_bad_nsrc
      $error("uart_irq_unit: NUM_SRC must match the fixed source map");
   end

   localparam logic [NUM_SRC-1:0] CTS_MASK = NUM_SRC'(1) << B_CTS_CHG;

   reg_sel_e         sel;
   logic             cts_tgl;
   logic [NUM_SRC-1:0] set_v, clr_v, stat, en;
   logic             irq_q;

   assign sel = reg_sel_e'(reg_sel);

   uirq_cts_toggle #(.STAGES(CTS_STAGES), .IDLE(CTS_IDLE)) u_cts (
      .clk      (clk),
      .rst      (rst),
      .line_i   (cts_i),
      .toggle_o (cts_tgl)
   );

   assign set_v = (evt_i & ~CTS_MASK) | (cts_tgl ? CTS_MASK : '0);
   assign clr_v = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;

   uirq_status_bank #(.N(NUM_SRC)) u_stat (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .stat_o (stat)
   );

   uirq_enable_reg #(
      .N       (NUM_SRC),
      .RX_MASK (RX_GRP_MASK),
      .TX_MASK (TX_GRP_MASK)
   ) u_en (
      .clk      (clk),
      .rst      (rst),
      .full_we  (reg_wr && sel == SEL_ENABLE),
      .full_d   (reg_wdata),
      .grp_we   (reg_wr && sel == SEL_GROUP),
      .rx_apply (reg_wdata[GW_RX_APPLY]),
      .rx_val   (reg_wdata[GW_RX_VAL]),
      .tx_apply (reg_wdata[GW_TX_APPLY]),
      .tx_val   (reg_wdata[GW_TX_VAL]),
      .en_o     (en)
   );

   always_ff @(posedge clk) begin
      if (rst) irq_q <= 1'b0;
      else     irq_q <= |(stat & en);
   end

   assign irq_o = irq_q;

   always_comb begin
      case (sel)
         SEL_ENABLE: reg_rdata = en;
         SEL_STATUS: reg_rdata = stat;
         default:    reg_rdata = '0;
      endcase
   end

   // R5
   irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> irq_o == $past(|(stat & en)));

   // R8
   cts_sets_chk: assert property (@(posedge clk) disable iff (rst)
      cts_tgl |=> stat[B_CTS_CHG]);

   // R9
   none_sel_chk: assert property (@(posedge clk) disable iff (rst)
      reg_wr && sel == SEL_NONE |=> en == $past(en));

endmodule

// File: tb/sim_uart_irq_unit.sv
`timescale 1ns/1ps
module sim_uart_irq_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [13:0] reg_wdata = '0;
   logic [13:0] reg_rdata;
   logic [13:0] evt_i = '0;
   logic        cts_i = 1'b1;
   logic        irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   uart_irq_unit u0 (
      .clk       (clk),
      .rst       (rst),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_i     (evt_i),
      .cts_i     (cts_i),
      .irq_o     (irq_o)
   );

   // {wr, sel[1:0], wdata[13:0], evt[13:0], exp_status[13:0], exp_irq}
   localparam int NV = 18;
   localparam logic [45:0] VEC [NV] = '{
      {1'b1, 2'd0, 14'h3FFF, 14'h0000, 14'h0000, 1'b0},
      {1'b0, 2'd0, 14'h0000, 14'h0001, 14'h0001, 1'b1},
      {1'b0, 2'd0, 14'h0000, 14'h2000, 14'h2001, 1'b1},
      {1'b1, 2'd1, 14'h0001, 14'h0000, 14'h2000, 1'b1},
      {1'b1, 2'd1, 14'h2000, 14'h0100, 14'h0100, 1'b1},
      {1'b1, 2'd1, 14'h0100, 14'h0100, 14'h0100, 1'b1},
      {1'b1, 2'd1, 14'h3FFF, 14'h0000, 14'h0000, 1'b0},
      {1'b1, 2'd0, 14'h0000, 14'h0000, 14'h0000, 1'b0},
      {1'b0, 2'd0, 14'h0000, 14'h0880, 14'h0880, 1'b0},
      {1'b1, 2'd2, 14'h0005, 14'h0000, 14'h0880, 1'b1},
      {1'b0, 2'd0, 14'h0000, 14'h0048, 14'h08C8, 1'b1},
      {1'b1, 2'd1, 14'h0880, 14'h0000, 14'h0048, 1'b0},
      {1'b1, 2'd2, 14'h000A, 14'h0000, 14'h0048, 1'b1},
      {1'b1, 2'd2, 14'h0004, 14'h0000, 14'h0048, 1'b1},
      {1'b1, 2'd1, 14'h0048, 14'h0000, 14'h0000, 1'b0},
      {1'b0, 2'd0, 14'h0000, 14'h0400, 14'h0000, 1'b0},
      {1'b1, 2'd3, 14'h3FFF, 14'h0000, 14'h0000, 1'b0},
      {1'b0, 2'd0, 14'h0000, 14'h1000, 14'h1000, 1'b0}
   };

   function automatic string vec_tag(int i);
      case (i)
         0, 7, 17:          return "R6";
         1, 8:              return "R2";
         2:                 return "R5";
         3, 4, 6, 14:       return "R3";
         5:                 return "R4";
         9, 10, 11, 12, 13: return "R7";
         15:                return "R8";
         default:           return "R9";
      endcase
   endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, logic [13:0] got, logic [13:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] s, logic [13:0] d);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      tick();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic read_check(string req, logic [1:0] s, logic [13:0] exp);
      reg_sel = s;
      #0.1;
      check(req, reg_rdata, exp);
   endtask

   initial begin
      repeat (3) tick();
      // R1 reset state
      read_check("R1 enable", 2'd0, 14'h0);
      read_check("R1 status", 2'd1, 14'h0);
      check("R1 irq", {13'b0, irq_o}, 14'h0);
      rst = 1'b0;
      tick();
      read_check("R1 status after release", 2'd1, 14'h0);

      for (int i = 0; i < NV; i++) begin
         reg_wr    = VEC[i][45];
         reg_sel   = VEC[i][44:43];
         reg_wdata = VEC[i][42:29];
         evt_i     = VEC[i][28:15];
         tick();
         reg_wr = 1'b0; reg_wdata = '0; evt_i = '0; reg_sel = 2'd1;
         tick();
         check($sformatf("%s vec %0d status", vec_tag(i), i), reg_rdata, VEC[i][14:1]);
         check($sformatf("%s vec %0d irq", vec_tag(i), i), {13'b0, irq_o}, {13'b0, VEC[i][0]});
      end

      // R7 group writes left only the transmit group enabled; R9 write ignored
      read_check("R7 enable readback", 2'd0, 14'h004C);
      read_check("R9 group select reads zero", 2'd2, 14'h0);
      read_check("R9 unused select reads zero", 2'd3, 14'h0);

      // R8 clear-to-send toggle timing
      reg_write(2'd1, 14'h3FFF);
      cts_i = 1'b0;
      reg_sel = 2'd1;
      tick();
      check("R8 edge1", reg_rdata, 14'h0000);
      tick();
      check("R8 edge2", reg_rdata, 14'h0000);
      tick();
      check("R8 edge3 set", reg_rdata, 14'h0400);
      reg_write(2'd1, 14'h0400);
      repeat (4) tick();
      read_check("R8 no retrigger while steady", 2'd1, 14'h0000);
      reg_write(2'd0, 14'h0400);
      cts_i = 1'b1;
      reg_sel = 2'd1;
      repeat (3) tick();
      check("R8 rising change set", reg_rdata, 14'h0400);
      tick();
      check("R5 irq from toggle", {13'b0, irq_o}, 14'h1);

      // R3 write strobe low does not clear
      reg_wr = 1'b0; reg_sel = 2'd1; reg_wdata = 14'h0400;
      tick();
      reg_wdata = '0;
      read_check("R3 no clear without strobe", 2'd1, 14'h0400);

      // R1 reset again clears everything
      rst = 1'b1;
      tick();
      rst = 1'b0;
      read_check("R1 status after reset", 2'd1, 14'h0);
      read_check("R1 enable after reset", 2'd0, 14'h0);
      check("R1 irq after reset", {13'b0, irq_o}, 14'h0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule